// File: doc/BRIEF.md
# Masked-Compare Repetitive Interrupt Timer

This block is a free-running up-counter that raises an interrupt when its value agrees with a programmed compare value. A per-bit ignore mask takes chosen counter bits out of that comparison. As a result, one compare setting can fire on a whole family of count values, such as every count whose low nibble is 5. The interrupt flag is sticky and stays set until software clears it.

An auto-clear option returns the counter to zero on every match, so the interrupt repeats with a period of the compare value plus one. With auto-clear off, the counter keeps running, wraps around at its top value, and flags every match it passes. Counting stops when the run-enable bit is low. It also stops while the debug-halt input is high, provided the debug gate bit is set.

Software reaches the block through a simple synchronous register port: a write strobe, a 2-bit register select, write data, and combinational read data. Address 0 is the counter, 1 is the compare value, 2 is the ignore mask and 3 is the control word.

Top module: `rep_irq_timer`

## Requirements
- R1: After reset the counter reads 0, the compare reads 0xFFFFFFFF, the mask reads 0, the control word reads 0x0000000C and `irq` is low.
- R2: A match exists in a cycle when every counter bit whose mask bit is 0 equals the matching compare bit; mask bits at 1 always agree. A match sets the flag at the next clock edge.
- R3: With auto-clear (control bit 1) at 0, the counter keeps adding one per running cycle through a match.
- R4: With auto-clear at 1, a match in a running cycle loads zero at the next edge, and counting goes on from zero.
- R5: The counter goes from 0xFFFFFFFF to 0 on the next running edge and keeps counting.
- R6: While run-enable (control bit 3) is 0, the counter holds its value.
- R7: While `dbgHalt` is high and the debug gate (control bit 2) is 1, the counter holds. With the gate at 0, `dbgHalt` has no effect.
- R8: Writing the control word with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag as it was, and the flag stays set until it is cleared.
- R9: A write to the counter sets the counter to the written value at the next edge, even when the timer is halted. If the same cycle holds an auto-clear match, the written value wins.
- R10: If a flag clear and a match fall in the same cycle, the flag stays set.
- R11: `irq` equals the flag, which reads as control bit 0.
- R12: Every register reads back its current value at any time. Control bits 31:4 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 counter, 1 compare, 2 mask, 3 control |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| dbgHalt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt, level of the sticky flag |

## Verification
A wrong count shows at the counter read port on the very next cycle, because the bench compares every read with its own model in every cycle. A faulty match or mask decode appears one edge later as a wrong `irq` level. With auto-clear on, the same fault also shows as a counter value that should have been zero. A mistake in the halt gating or in write priority stays visible, since the counter holds or jumps to a value the model does not predict.

// File: rtl/rep_timer_pkg.sv
package rep_timer_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT  = 2'd0,
    REG_MATCH  = 2'd1,
    REG_IGNORE = 2'd2,
    REG_CTRL   = 2'd3
  } regSel_e;

  localparam int CTL_FLAG    = 0;
  localparam int CTL_AUTOCLR = 1;
  localparam int CTL_DBGGATE = 2;
  localparam int CTL_RUNEN   = 3;
  localparam int CTL_W       = 4;

  typedef struct packed {
    logic ldCount;
    logic ldMatch;
    logic ldIgnore;
    logic advance;
    logic zeroOnHit;
  } dpStrobe_t;

endpackage

// File: rtl/rep_timer_ctrl.sv
module rep_timer_ctrl
  import rep_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  ctlData,
  input  logic              dbgHalt,
  input  logic              hit,
  output dpStrobe_t         stb,
  output logic [DATA_W-1:0] ctlWord,
  output logic              irq
);

  logic flagQ, autoClrQ, dbgGateQ, runEnQ;
  logic flagNext;
  logic wrCtl;

  assign wrCtl = wrEn && (addr == REG_CTRL);

  // a new match outranks a software clear
  always_comb begin
    if (hit)
      flagNext = 1'b1;
    else if (wrCtl && ctlData[CTL_FLAG])
      flagNext = 1'b0;
    else
      flagNext = flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      autoClrQ <= 1'b0;
      dbgGateQ <= 1'b1;
      runEnQ   <= 1'b1;
    end else begin
      flagQ <= flagNext;
      if (wrCtl) begin
        autoClrQ <= ctlData[CTL_AUTOCLR];
        dbgGateQ <= ctlData[CTL_DBGGATE];
        runEnQ   <= ctlData[CTL_RUNEN];
      end
    end
  end

  always_comb begin
    stb.ldCount   = wrEn && (addr == REG_COUNT);
    stb.ldMatch   = wrEn && (addr == REG_MATCH);
    stb.ldIgnore  = wrEn && (addr == REG_IGNORE);
    stb.advance   = runEnQ && !(dbgGateQ && dbgHalt);
    stb.zeroOnHit = autoClrQ;
  end

  always_comb begin
    ctlWord              = '0;
    ctlWord[CTL_FLAG]    = flagQ;
    ctlWord[CTL_AUTOCLR] = autoClrQ;
    ctlWord[CTL_DBGGATE] = dbgGateQ;
    ctlWord[CTL_RUNEN]   = runEnQ;
  end

  assign irq = flagQ;

endmodule

// File: rtl/rep_timer_dp.sv
module rep_timer_dp
  import rep_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              hit,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] matchQ,
  output logic [DATA_W-1:0] ignoreQ
);

  localparam logic [DATA_W-1:0] MATCH_RST = '1;
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);

  logic [DATA_W-1:0] bitOk;
  logic [DATA_W-1:0] countNext;

  // per-bit agreement; a set ignore bit forces agreement
  for (genvar b = 0; b < DATA_W; b++) begin : gBit
    assign bitOk[b] = ignoreQ[b] | ~(countQ[b] ^ matchQ[b]);
  end

  assign hit = &bitOk;

  // priority: software load, hold, clear on match, increment
  always_comb begin
    if (stb.ldCount)
      countNext = wrData;
    else if (!stb.advance)
      countNext = countQ;
    else if (hit && stb.zeroOnHit)
      countNext = '0;
    else
      countNext = countQ + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      matchQ  <= MATCH_RST;
      ignoreQ <= '0;
    end else begin
      countQ <= countNext;
      if (stb.ldMatch)  matchQ  <= wrData;
      if (stb.ldIgnore) ignoreQ <= wrData;
    end
  end

endmodule

// File: rtl/rep_irq_timer.sv
module rep_irq_timer
  import rep_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              dbgHalt,
  output logic              irq
);

  dpStrobe_t         stb;
  logic              hit;
  logic [DATA_W-1:0] countQ, matchQ, ignoreQ, ctlWord;

  rep_timer_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .ctlData (wrData[CTL_W-1:0]),
    .dbgHalt (dbgHalt),
    .hit     (hit),
    .stb     (stb),
    .ctlWord (ctlWord),
    .irq     (irq)
  );

  rep_timer_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .hit     (hit),
    .countQ  (countQ),
    .matchQ  (matchQ),
    .ignoreQ (ignoreQ)
  );

  always_comb begin
    case (addr)
      REG_COUNT:  rdData = countQ;
      REG_MATCH:  rdData = matchQ;
      REG_IGNORE: rdData = ignoreQ;
      default:    rdData = ctlWord;
    endcase
  end

endmodule

// File: rtl/rep_timer_chk.sv
module rep_timer_chk
  import rep_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input logic              hit,
  input dpStrobe_t         stb,
  input logic [DATA_W-1:0] countQ
);

  a_r2_match_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> irq);

  a_r3_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.ldCount && !(hit && stb.zeroOnHit))
      |=> countQ == DATA_W'($past(countQ) + DATA_W'(1)));

  a_r4_zero_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && hit && stb.zeroOnHit && !stb.ldCount) |=> countQ == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.ldCount) |=> $stable(countQ));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && addr == REG_CTRL && wrData[CTL_FLAG])) |=> irq);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_CTRL && wrData[CTL_FLAG] && !hit) |=> !irq);

  a_r9_sw_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_COUNT) |=> countQ == $past(wrData));

  a_r11_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    (addr == REG_CTRL) |-> rdData[CTL_FLAG] == irq);

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == REG_CTRL) |-> rdData[DATA_W-1:CTL_W] == '0);

endmodule

bind rep_irq_timer rep_timer_chk #(.DATA_W(DATA_W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .irq    (irq),
  .hit    (hit),
  .stb    (stb),
  .countQ (countQ)
);

// File: tb/sim_rep_irq_timer.sv
`timescale 1ns/100ps
module sim_rep_irq_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        dbgHalt = 1'b0;
  logic        irq;

  int  nChk = 0;
  int  nErr = 0;
  bit  done = 1'b0;
  logic haltV = 1'b0;

  // reference model state
  logic [31:0] mCnt, mCmp, mMask;
  logic mFlag, mClr, mDbg, mEn;

  always #2 clk = ~clk;

  rep_irq_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dbgHalt(dbgHalt), .irq(irq)
  );

  function automatic logic [31:0] mdlRead(input logic [1:0] a);
    case (a)
      2'd0: return mCnt;
      2'd1: return mCmp;
      2'd2: return mMask;
      default: return {28'b0, mEn, mDbg, mClr, mFlag};
    endcase
  endfunction

  function automatic string tagFor(input logic [1:0] a);
    case (a)
      2'd0: return "R3";
      2'd3: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdlAdvance(input logic we, input logic [1:0] a, input logic [31:0] d, input logic h);
    logic m, run;
    logic [31:0] cN;
    m   = ((mCnt ^ mCmp) & ~mMask) == 32'd0;
    run = mEn && !(mDbg && h);
    if (we && a == 2'd0)   cN = d;
    else if (!run)         cN = mCnt;
    else if (m && mClr)    cN = 32'd0;
    else                   cN = mCnt + 32'd1;
    if (m) mFlag = 1'b1;
    else if (we && a == 2'd3 && d[0]) mFlag = 1'b0;
    if (we && a == 2'd1) mCmp = d;
    if (we && a == 2'd2) mMask = d;
    if (we && a == 2'd3) begin
      mClr = d[1]; mDbg = d[2]; mEn = d[3];
    end
    mCnt = cN;
  endtask

  // one clock: drive at negedge, compare with model, advance
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d);
    wrEn = we; addr = a; wrData = d; dbgHalt = haltV;
    #0.5;
    chk(tagFor(a), rdData, mdlRead(a));
    chk("R11", {31'b0, irq}, {31'b0, mFlag});
    mdlAdvance(we, a, d, haltV);
    @(posedge clk);
    @(negedge clk);
  endtask

  // read without advancing the clock
  task automatic look(input string tag, input logic [1:0] a, input logic [31:0] exp);
    wrEn = 1'b0; addr = a;
    #0.1;
    chk(tag, rdData, exp);
  endtask

  task automatic lookIrq(input string tag, input logic exp);
    #0.1;
    chk(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nChk, nErr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mCnt = '0; mCmp = '1; mMask = '0;
    mFlag = 1'b0; mClr = 1'b0; mDbg = 1'b1; mEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    look("R1", 2'd0, 32'h0);
    look("R1", 2'd1, 32'hFFFF_FFFF);
    look("R1", 2'd2, 32'h0);
    look("R1", 2'd3, 32'h0000_000C);
    lookIrq("R1", 1'b0);
    step(0, 2'd0, 0);

    // R5 wrap, R2 match at top value with reset compare
    step(1, 2'd0, 32'hFFFF_FFFE);
    look("R5", 2'd0, 32'hFFFF_FFFE);
    step(0, 2'd0, 0);
    look("R5", 2'd0, 32'hFFFF_FFFF);
    step(0, 2'd0, 0);
    look("R5", 2'd0, 32'h0);
    lookIrq("R2", 1'b1);
    step(1, 2'd3, 32'hD);
    lookIrq("R8", 1'b0);
    look("R8", 2'd3, 32'hC);

    // R3 runs through a match without clearing
    step(1, 2'd1, 32'd10);
    step(1, 2'd0, 32'd9);
    look("R3", 2'd0, 32'd9);
    step(0, 2'd0, 0);
    look("R3", 2'd0, 32'd10);
    step(0, 2'd0, 0);
    look("R3", 2'd0, 32'd11);
    lookIrq("R2", 1'b1);
    step(1, 2'd3, 32'hC);
    lookIrq("R8", 1'b1);
    step(1, 2'd3, 32'hD);
    lookIrq("R8", 1'b0);

    // R2 masked compare: low nibble 5 only
    step(1, 2'd1, 32'd5);
    step(1, 2'd2, 32'hFFFF_FFF0);
    step(1, 2'd0, 32'h1234_5673);
    lookIrq("R2", 1'b0);
    step(0, 2'd0, 0);
    step(0, 2'd0, 0);
    look("R2", 2'd0, 32'h1234_5675);
    lookIrq("R2", 1'b0);
    step(0, 2'd0, 0);
    lookIrq("R2", 1'b1);

    // R4 auto-clear period
    step(1, 2'd2, 32'h0);
    step(1, 2'd1, 32'd4);
    step(1, 2'd3, 32'hF);
    step(1, 2'd0, 32'd0);
    look("R4", 2'd0, 32'd0);
    for (int i = 1; i <= 4; i++) begin
      step(0, 2'd0, 0);
      look("R4", 2'd0, i);
    end
    step(0, 2'd0, 0);
    look("R4", 2'd0, 32'd0);
    lookIrq("R4", 1'b1);
    step(0, 2'd0, 0);
    look("R4", 2'd0, 32'd1);

    // R9 software load beats auto-clear
    step(1, 2'd3, 32'hF);
    step(0, 2'd0, 0);
    step(0, 2'd0, 0);
    look("R9", 2'd0, 32'd4);
    step(1, 2'd0, 32'd100);
    look("R9", 2'd0, 32'd100);

    // R10 clear and match together
    step(1, 2'd0, 32'd4);
    step(1, 2'd3, 32'hF);
    lookIrq("R10", 1'b1);
    look("R4", 2'd0, 32'd0);

    // R6 run-enable off
    step(1, 2'd3, 32'h4);
    look("R6", 2'd0, 32'd1);
    step(0, 2'd0, 0);
    look("R6", 2'd0, 32'd1);
    step(1, 2'd0, 32'd55);
    look("R9", 2'd0, 32'd55);
    step(0, 2'd0, 0);
    look("R6", 2'd0, 32'd55);

    // R7 debug gate
    step(1, 2'd3, 32'hC);
    haltV = 1'b1;
    step(0, 2'd0, 0);
    look("R7", 2'd0, 32'd55);
    step(1, 2'd3, 32'h8);
    look("R7", 2'd0, 32'd55);
    step(0, 2'd0, 0);
    look("R7", 2'd0, 32'd56);
    haltV = 1'b0;

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 15);
      haltV = ($urandom_range(0, 3) == 0);
      case (op)
        0: step(1, 2'd0, mCmp - 32'd3 + 32'($urandom_range(0, 6)));
        1: begin
          d = ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 63));
          step(1, 2'd1, d);
        end
        2: begin
          d = ($urandom_range(0, 1) == 0) ? ($urandom & 32'hFFFF_FFC0) : $urandom;
          step(1, 2'd2, d);
        end
        3: begin
          d = {$urandom} & 32'hFFFF_FFF7;
          d[3] = ($urandom_range(0, 3) != 0);
          step(1, 2'd3, d);
        end
        default: step(0, 2'($urandom_range(0, 3)), 0);
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

endmodule